// File: doc/BRIEF.md
# Field-to-Progressive Line Deinterlacer

The block turns two stored interlaced fields into progressive 24-bit RGB frames. It walks through an output frame of twice the field height. For every output pixel it drives two read ports into the field stores. Each read port names a field, a line and a pixel, and the store answers in the same cycle. The block averages the two returned pixels channel by channel and registers the result into a stallable valid/ready output stream. The stream carries a frame start flag and a line start flag.

Two modes are selectable at run time. Weave interleaves the even and odd fields unchanged. Line interpolation keeps the lines of the current field and fills each missing line from the current-field lines directly above and below it. The current field is the incoming field bit, optionally inverted by a swap control. Mode, swap, field bit and dimensions are sampled only when a new output frame begins.

Top module: `fld2prog_deint`

## Requirements
- R1: While reset is asserted and until the first pixel is produced, `out_valid` is low.
- R2: A pixel is transferred on a rising edge where `out_valid` and `out_ready` are both high. While `out_ready` is low and `out_valid` is high, `out_pix`, `out_valid`, `out_vsync` and `out_hsync` hold their values.
- R3: An output frame is 2×`lpf` lines of `ppl` pixels. `out_vsync` is high exactly on the first pixel of a frame, and `out_hsync` is high exactly on the first pixel of each line. Frames follow each other without gaps in the count.
- R4: Mode 0 (weave): output line y is line y/2 of field (y mod 2), where field 0 is even and field 1 is odd, copied unchanged whatever the current field.
- R5: Mode 1 (interpolation): with current parity c, output lines with y mod 2 = c are line y/2 of field c unchanged. Every other line is the per-channel average, rounded toward zero, of output lines y−1 and y+1 taken from field c. Channels are bits 23:16, 15:8 and 7:0.
- R6: In interpolation, a missing line with no neighbour above (y=0) or below (y=2·lpf−1) repeats its single existing neighbour.
- R7: Mode 2 and mode 3 produce the same output as mode 1.
- R8: The current parity c is `fld_id` XOR `fld_swap`.
- R9: `mode_sel`, `fld_id`, `fld_swap`, `ppl` and `lpf` take effect only at the start of an output frame. A change during a frame leaves the rest of that frame unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | 0 weave, 1 interpolation, 2/3 as 1 |
| fld_id | input | 1 | Current field, 0 even, 1 odd |
| fld_swap | input | 1 | Inverts the meaning of `fld_id` |
| ppl | input | 16 | Pixels per line (≥2) |
| lpf | input | 16 | Lines per field (≥1) |
| rda_fld | output | 1 | Read port A field select |
| rda_line | output | 16 | Read port A line within field |
| rda_pix | output | 16 | Read port A pixel index |
| rda_data | input | 24 | Read port A pixel, same cycle |
| rdb_fld | output | 1 | Read port B field select |
| rdb_line | output | 16 | Read port B line within field |
| rdb_pix | output | 16 | Read port B pixel index |
| rdb_data | input | 24 | Read port B pixel, same cycle |
| out_pix | output | 24 | Output RGB pixel |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_vsync | output | 1 | First pixel of output frame |
| out_hsync | output | 1 | First pixel of output line |

## Verification
Read addresses follow the scan position combinationally. The store data is registered once, so a pixel shows on the output one edge after its addresses were presented, and it leaves on the first edge where ready is also high. The bench therefore evaluates each transfer at the falling edge before the edge that completes it. It first drives the new ready value, then compares the held output against its own frame counters. A stalled pixel is compared again at the next falling edge. Configuration changes are applied mid-frame, so the bench model, which latches configuration on the first pixel of each frame, predicts exactly when they apply.

// File: rtl/deint_pkg.sv
package deint_pkg;
  parameter int CH_W  = 8;
  parameter int NCH   = 3;
  parameter int PIX_W = CH_W * NCH;
  parameter int DIM_W = 16;

  typedef logic [PIX_W-1:0] pix_t;

  typedef enum logic [1:0] {
    MODE_WEAVE = 2'd0,
    MODE_LERP  = 2'd1,
    MODE_ADAPT = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;

  typedef struct packed {
    logic [1:0]       mode;
    logic             par;
    logic [DIM_W-1:0] ppl;
    logic [DIM_W-1:0] lpf;
  } cfg_t;
endpackage

// File: rtl/deint_scan.sv
module deint_scan
  import deint_pkg::*;
#(
  parameter int W = DIM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  cfg_t         live,
  output cfg_t         eff,
  output logic [W-1:0] x,
  output logic [W:0]   y,
  output logic         origin
);
  logic [W-1:0] x_q, x_d;
  logic [W:0]   y_q, y_d;
  cfg_t         cfg_q, cfg_d;
  logic         last_x, last_y;

  assign origin = (x_q == '0) && (y_q == '0);
  assign eff    = origin ? live : cfg_q;
  assign last_x = (x_q == eff.ppl - W'(1));
  assign last_y = (y_q == {eff.lpf, 1'b0} - (W+1)'(1));
  assign x      = x_q;
  assign y      = y_q;

  always_comb begin
    x_d   = x_q;
    y_d   = y_q;
    cfg_d = cfg_q;
    if (adv) begin
      if (origin) cfg_d = live;
      if (last_x) begin
        x_d = '0;
        y_d = last_y ? '0 : y_q + (W+1)'(1);
      end else begin
        x_d = x_q + W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      cfg_q <= '0;
    end else begin
      x_q   <= x_d;
      y_q   <= y_d;
      cfg_q <= cfg_d;
    end
  end

  // R9: configuration is frozen away from the frame origin
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !origin) |=> $stable(cfg_q));

  // R3: the last pixel of a frame wraps to the origin
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_x && last_y) |=> origin);
endmodule

// File: rtl/deint_addr.sv
module deint_addr
  import deint_pkg::*;
#(
  parameter int W = DIM_W
) (
  input  logic [1:0]   mode,
  input  logic         par,
  input  logic [W-1:0] lpf,
  input  logic [W-1:0] x,
  input  logic [W:0]   y,
  output logic         a_fld,
  output logic [W-1:0] a_line,
  output logic         b_fld,
  output logic [W-1:0] b_line,
  output logic [W-1:0] pix
);
  logic [W-1:0] k;
  logic         yp;

  assign k   = y[W:1];
  assign yp  = y[0];
  assign pix = x;

  always_comb begin
    a_fld  = yp;
    b_fld  = yp;
    a_line = k;
    b_line = k;
    if (mode != MODE_WEAVE) begin
      a_fld = par;
      b_fld = par;
      if (yp != par) begin
        if (!par) begin
          b_line = (({1'b0, k} + (W+1)'(1)) < {1'b0, lpf}) ? k + W'(1) : k;
        end else begin
          a_line = (k == '0) ? k : k - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/deint_out.sv
module deint_out
  import deint_pkg::*;
#(
  parameter int CW = CH_W,
  parameter int NC = NCH,
  localparam int PW = CW * NC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] a_data,
  input  logic [PW-1:0] b_data,
  input  logic          frame_first,
  input  logic          line_first,
  input  logic          out_ready,
  output logic          adv,
  output logic          out_valid,
  output logic [PW-1:0] out_pix,
  output logic          out_vsync,
  output logic          out_hsync
);
  logic [PW-1:0] mean;
  logic          vld_q;
  logic [PW-1:0] pix_q;
  logic          vs_q, hs_q;

  for (genvar c = 0; c < NC; c++) begin : g_ch
    logic [CW:0] sum;
    assign sum                 = {1'b0, a_data[c*CW +: CW]} + {1'b0, b_data[c*CW +: CW]};
    assign mean[c*CW +: CW]    = sum[CW:1];
  end

  assign adv = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      pix_q <= '0;
      vs_q  <= 1'b0;
      hs_q  <= 1'b0;
    end else if (adv) begin
      vld_q <= 1'b1;
      pix_q <= mean;
      vs_q  <= frame_first;
      hs_q  <= line_first;
    end
  end

  assign out_valid = vld_q;
  assign out_pix   = pix_q;
  assign out_vsync = vs_q;
  assign out_hsync = hs_q;

  // R2: a stalled pixel keeps data, valid and flags
  p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)
                                   && $stable(out_vsync) && $stable(out_hsync)));

  // R3: a frame start is always also a line start
  p_vs_implies_hs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_vsync) |-> out_hsync);
endmodule

// File: rtl/fld2prog_deint.sv
module fld2prog_deint
  import deint_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  mode_sel,
  input  logic        fld_id,
  input  logic        fld_swap,
  input  logic [15:0] ppl,
  input  logic [15:0] lpf,
  output logic        rda_fld,
  output logic [15:0] rda_line,
  output logic [15:0] rda_pix,
  input  logic [23:0] rda_data,
  output logic        rdb_fld,
  output logic [15:0] rdb_line,
  output logic [15:0] rdb_pix,
  input  logic [23:0] rdb_data,
  output logic [23:0] out_pix,
  output logic        out_valid,
  input  logic        out_ready,
  output logic        out_vsync,
  output logic        out_hsync
);
  logic [1:0]       rst_sync;
  logic             rst_ni;
  cfg_t             live, eff;
  logic [DIM_W-1:0] x;
  logic [DIM_W:0]   y;
  logic             origin, adv;
  logic [DIM_W-1:0] pix_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign live = '{mode: mode_sel, par: fld_id ^ fld_swap, ppl: ppl, lpf: lpf};

  deint_scan #(.W(DIM_W)) u_scan (
    .clk(clk), .rst_n(rst_ni), .adv(adv), .live(live), .eff(eff),
    .x(x), .y(y), .origin(origin)
  );

  deint_addr #(.W(DIM_W)) u_addr (
    .mode(eff.mode), .par(eff.par), .lpf(eff.lpf), .x(x), .y(y),
    .a_fld(rda_fld), .a_line(rda_line), .b_fld(rdb_fld), .b_line(rdb_line),
    .pix(pix_idx)
  );

  assign rda_pix = pix_idx;
  assign rdb_pix = pix_idx;

  deint_out #(.CW(CH_W), .NC(NCH)) u_out (
    .clk(clk), .rst_n(rst_ni), .a_data(rda_data), .b_data(rdb_data),
    .frame_first(origin), .line_first(x == '0), .out_ready(out_ready),
    .adv(adv), .out_valid(out_valid), .out_pix(out_pix),
    .out_vsync(out_vsync), .out_hsync(out_hsync)
  );

  // R6: both read lines stay inside the field, edges included
  p_line_in_range_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (eff.lpf != '0) |-> (rda_line < eff.lpf && rdb_line < eff.lpf));

  // R4: weave reads one line of the field chosen by output line parity
  p_weave_one_line_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (eff.mode == MODE_WEAVE) |-> (rda_line == rdb_line && rda_fld == y[0] && rdb_fld == y[0]));

  // R1: no valid output while held in reset
  p_idle_in_reset_r1: assert property (@(posedge clk) !rst_ni |=> !out_valid || rst_ni);
endmodule

// File: tb/sim_fld2prog_deint.sv
`timescale 1ns/1ps
module sim_fld2prog_deint;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode_sel;
  logic        fld_id, fld_swap;
  logic [15:0] ppl, lpf;
  logic        rda_fld, rdb_fld;
  logic [15:0] rda_line, rda_pix, rdb_line, rdb_pix;
  logic [23:0] rda_data, rdb_data, out_pix;
  logic        out_valid, out_ready, out_vsync, out_hsync;
  int          errs = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  function automatic logic [23:0] pv(int f, int l, int p);
    logic [7:0] r, g, b;
    r = 8'(200 + f * 40 + l * 13 + p * 7);
    g = 8'(l * 51 + p * 3 + f);
    b = 8'(255 - l * 9 - p * 2 - f * 5);
    return {r, g, b};
  endfunction

  assign rda_data = pv(int'(rda_fld), int'(rda_line), int'(rda_pix));
  assign rdb_data = pv(int'(rdb_fld), int'(rdb_line), int'(rdb_pix));

  fld2prog_deint u0 (.*);

  function automatic logic [23:0] mix(logic [23:0] a, logic [23:0] b);
    logic [23:0] m;
    for (int c = 0; c < 3; c++) m[c*8 +: 8] = 8'((int'(a[c*8 +: 8]) + int'(b[c*8 +: 8])) / 2);
    return m;
  endfunction

  function automatic logic [23:0] expect_pix(int md, int c, int nl, int y, int x);
    int up, dn;
    if (md == 0) return pv(y % 2, y / 2, x);
    if (y % 2 == c) return pv(c, y / 2, x);
    up = y - 1;
    dn = y + 1;
    if (up < 0) up = dn;
    if (dn > 2 * nl - 1) dn = up;
    return mix(pv(c, up / 2, x), pv(c, dn / 2, x));
  endfunction

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply_cfg(int ci);
    ppl      = (ci >= 12) ? 16'd3 : 16'd4;
    lpf      = (ci >= 12) ? 16'd2 : 16'd3;
    mode_sel = 2'((ci / 4) % 3);
    fld_id   = ci[0];
    fld_swap = ci[1];
  endtask

  initial begin
    int ex, ey, amode, ac, aswap, ap, al, frames, ci, cyc;
    bit change_due, chg_in_frame, hold, done, missing, edge_ln;
    logic [23:0] hp, e;
    logic hv, hh;
    logic [7:0] lfsr;
    string tag;
    ex = 0; ey = 0; frames = 0; ci = 0; cyc = 0;
    amode = 0; ac = 0; aswap = 0; ap = 4; al = 3;
    change_due = 0; chg_in_frame = 0; hold = 0; done = 0;
    hp = '0; hv = 0; hh = 0; lfsr = 8'hA5;
    apply_cfg(0);
    out_ready = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid in reset", 24'(out_valid), 24'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after release", 24'(out_valid), 24'd0);
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (hold) begin
        chk(out_valid == 1'b1, "R2 valid held", 24'(out_valid), 24'd1);
        chk(out_pix == hp, "R2 pixel held", out_pix, hp);
        chk(out_vsync == hv && out_hsync == hh, "R2 flags held",
            24'({out_vsync, out_hsync}), 24'({hv, hh}));
        hold = 0;
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = (lfsr[1:0] != 2'b00);
      if (out_valid && out_ready) begin
        if (ex == 0 && ey == 0) begin
          amode = int'(mode_sel);
          ac    = int'(fld_id ^ fld_swap);
          aswap = int'(fld_swap);
          ap    = int'(ppl);
          al    = int'(lpf);
          chg_in_frame = 0;
        end
        e = expect_pix(amode, ac, al, ey, ex);
        missing = (amode != 0) && (ey % 2 != ac);
        edge_ln = (ey == 0) || (ey == 2 * al - 1);
        if (chg_in_frame)          tag = "R9 pixel after mid-frame change";
        else if (amode == 0)       tag = "R4 weave pixel";
        else if (missing && edge_ln) tag = "R6 edge line pixel";
        else if (amode == 2)       tag = "R7 mode 2 pixel";
        else if (aswap == 1)       tag = "R8 swapped parity pixel";
        else                       tag = "R5 interpolated pixel";
        chk(out_pix == e, tag, out_pix, e);
        chk(out_vsync == (ex == 0 && ey == 0), "R3 vsync", 24'(out_vsync), 24'(ex == 0 && ey == 0));
        chk(out_hsync == (ex == 0), "R3 hsync", 24'(out_hsync), 24'(ex == 0));
        ex++;
        if (ex == ap) begin
          ex = 0;
          ey++;
          if (ey == 2 * al) begin
            ey = 0;
            frames++;
            if (frames % 2 == 0) change_due = 1;
          end
        end
        if (change_due && ey == 1 && ex == 1) begin
          change_due = 0;
          ci++;
          if (ci == 24) done = 1;
          else begin
            apply_cfg(ci);
            chg_in_frame = 1;
          end
        end
      end else if (out_valid) begin
        hold = 1;
        hp = out_pix;
        hv = out_vsync;
        hh = out_hsync;
      end
    end
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected fewer than 20000", cyc);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule